// File: doc/BRIEF.md
# Dual-Register Interrupt Status Controller

This block gathers twelve single-cycle event pulses from a general-purpose instrument bus interface into two 8-bit status registers. A CPU reads and writes it through a small register port. Each event sets its status bit whatever the mask says. Each of the twelve bits also has an enable bit, and the interrupt line is high while any enabled bit is set. Reading a status register returns its contents and then clears it. An event that lands while that register is being read is parked and written in after the clear, so it is not lost.

The second status register also shows four bits that are status only. The top bit mirrors the interrupt line. The next three show serial-poll, lockout and remote levels. None of these four can raise the interrupt, and none is cleared by a read. In talk-only or listen-only operation the address-change event is dropped. A power-on local message clears both status registers.

Top module: `intr_status_ctrl`

## Requirements
- R1: After reset, both status registers read as zero, both mask registers are zero and `irq_o` is low.
- R2: A pulse on an event input sets the matching status bit whatever its mask. Register 1 (address 0) bit i follows `evt_a_i[i]`. Register 2 (address 1) bit i, for i = 0..3, follows `evt_b_i[i]`.
- R3: `irq_o` is high exactly when some status bit is set and its mask bit is also 1. Mask register 1 (write address 0) bit i enables status 1 bit i. Mask register 2 (write address 1) bits 3:0 enable status 2 bits 3:0.
- R4: A read (`rd_i` high with `addr_i` selecting a register) returns the register on `rdata_o`. A strobe held for several cycles counts as one read. The register is cleared on the clock edge right after the strobe falls.
- R5: An event for the register being read, whether it arrives during the strobe or on the clear edge, appears in that register after the clear. An event for the other register is recorded at once.
- R6: A high `pon_i` clears both status registers, including any parked events.
- R7: Status register 2 bit 7 reads `irq_o`, and bits 6, 5 and 4 read `lvl_i[2]`, `lvl_i[1]` and `lvl_i[0]`. These bits never drive `irq_o` and a read does not clear them.
- R8: While `solo_mode_i` is high, a pulse on `evt_b_i[0]` (address change) is not recorded.
- R9: Bits 7:6 of a mask register 2 write drive `dma_en_o[1:0]` and have no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pon_i | input | 1 | Power-on local message, clears status |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Mask write strobe |
| addr_i | input | 1 | Register select: 0 = register 1, 1 = register 2 |
| wdata_i | input | 8 | Mask write data |
| rdata_o | output | 8 | Selected status register |
| evt_a_i | input | 8 | Event pulses for status register 1 |
| evt_b_i | input | 4 | Change-event pulses for status register 2 |
| lvl_i | input | 3 | Serial-poll, lockout and remote levels |
| solo_mode_i | input | 1 | Talk-only or listen-only mode |
| irq_o | output | 1 | Interrupt request |
| dma_en_o | output | 2 | DMA enables from mask register 2 |

## Verification
The hardest case to reach is an event that lands exactly on the clear edge, the one cycle after the read strobe falls. Only there does an event merge with parked bits in place of either being parked or being set directly. The bench lines an event pulse up with the falling edge of the strobe to hit that edge. It also pulses events in the middle of a long strobe, aimed both at the register being read and at the other register. A fresh read afterwards shows that each event landed exactly once, in the right place.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned N_REGS = 2;
  typedef enum logic {
    SEL_ST1 = 1'b0,
    SEL_ST2 = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/isc_rd_seq.sv
module isc_rd_seq #(
  parameter int unsigned NREG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            sel_i,
  output logic [NREG-1:0] hold_o,
  output logic [NREG-1:0] clr_o
);
  logic rd_q;
  logic sel_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_i) sel_q <= sel_i;
    end
  end

  assign fall = rd_q & ~rd_i;

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign hold_o[k] = rd_i & (32'(sel_i) == k);
    assign clr_o[k]  = fall & (32'(sel_q) == k);
  end

  // R4
  clr_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |=> !(|clr_o));
endmodule

// File: rtl/isc_evt_bank.sv
module isc_evt_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pon_i,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      pend_q <= '0;
    end else if (pon_i) begin
      stat_q <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      stat_q <= pend_q | evt_i;   // clear, then land parked and same-cycle events
      pend_q <= '0;
    end else if (hold_i) begin
      pend_q <= pend_q | evt_i;
    end else begin
      stat_q <= stat_q | evt_i;
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;

  // R4
  stat_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !pon_i) |=> $stable(stat_q));
  // R5
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !pon_i && (|evt_i)) |=> (|pend_q));
  // R6
  pon_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pon_i |=> (stat_q == '0 && pend_q == '0));
endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl #(
  parameter int unsigned EVT_A_W = 8,
  parameter int unsigned EVT_B_W = 4,
  parameter int unsigned LVL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pon_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [EVT_A_W-1:0] evt_a_i,
  input  logic [EVT_B_W-1:0] evt_b_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               solo_mode_i,
  output logic               irq_o,
  output logic [1:0]         dma_en_o
);
  import isc_pkg::*;

  localparam int unsigned DMA_LO = REG_W - 2;

  logic [N_REGS-1:0]  hold;
  logic [N_REGS-1:0]  clr;
  logic [EVT_A_W-1:0] stat_a, pend_a, mask_a_q;
  logic [EVT_B_W-1:0] stat_b, pend_b, mask_b_q, evt_b_g;
  logic [1:0]         dma_q;
  logic               unused_wbits;

  isc_rd_seq #(.NREG(N_REGS)) u_rd_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_i),
    .sel_i (addr_i),
    .hold_o(hold),
    .clr_o (clr)
  );

  // address-change event dropped in talk-only / listen-only operation
  assign evt_b_g = {evt_b_i[EVT_B_W-1:1], evt_b_i[0] & ~solo_mode_i};

  isc_evt_bank #(.W(EVT_A_W)) u_bank_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pon_i (pon_i),
    .hold_i(hold[SEL_ST1]),
    .clr_i (clr[SEL_ST1]),
    .evt_i (evt_a_i),
    .stat_o(stat_a),
    .pend_o(pend_a)
  );

  isc_evt_bank #(.W(EVT_B_W)) u_bank_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pon_i (pon_i),
    .hold_i(hold[SEL_ST2]),
    .clr_i (clr[SEL_ST2]),
    .evt_i (evt_b_g),
    .stat_o(stat_b),
    .pend_o(pend_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
      dma_q    <= '0;
    end else if (wr_i) begin
      if (addr_i == SEL_ST1) begin
        mask_a_q <= wdata_i[EVT_A_W-1:0];
      end else begin
        mask_b_q <= wdata_i[EVT_B_W-1:0];
        dma_q    <= wdata_i[REG_W-1:DMA_LO];
      end
    end
  end

  assign unused_wbits = ^wdata_i[DMA_LO-1:EVT_B_W];

  assign irq_o    = (|(stat_a & mask_a_q)) | (|(stat_b & mask_b_q));
  assign dma_en_o = dma_q;
  assign rdata_o  = (addr_i == SEL_ST2) ? {irq_o, lvl_i, stat_b}
                                        : stat_a;

  // R3
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_a_q == '0 && mask_b_q == '0) |-> !irq_o);
  // R8
  solo_adsc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_b[0]) |-> ($past(!solo_mode_i) || $past(pend_b[0])));
  // R5
  pend_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !$past(rd_i)) |-> (pend_a == '0 && pend_b == '0));
endmodule

// File: tb/intr_status_ctrl_tb_top.sv
module intr_status_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pon = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0, solo = 1'b0;
  logic [7:0] wdata = '0, evt_a = '0;
  logic [3:0] evt_b = '0;
  logic [2:0] lvl = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] dma;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  intr_status_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pon_i(pon), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_a_i(evt_a),
    .evt_b_i(evt_b), .lvl_i(lvl), .solo_mode_i(solo), .irq_o(irq),
    .dma_en_o(dma)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // monitor: compare the first cycle of every read against the scoreboard
  always @(posedge clk) begin
    #2;
    if (rd && !rd_d) begin
      if (exp_q.size() == 0) begin
        chk(8'hxx, 8'h00, "scoreboard empty");
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
    rd_d = rd;
  end

  task automatic rd_begin(input logic a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); addr = a; rd = 1'b1;
  endtask

  task automatic rd_end();
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic a, input logic [7:0] e, input string t, input int n);
    rd_begin(a, e, t);
    repeat (n - 1) @(negedge clk);
    rd_end();
  endtask

  task automatic pulse(input logic [7:0] a, input logic [3:0] b);
    @(negedge clk); evt_a = a; evt_b = b;
    @(negedge clk); evt_a = '0; evt_b = '0;
  endtask

  task automatic wr_mask(input logic a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    chk({6'd0, dma}, 8'h00, "R1 dma after reset");
    rd_reg(1'b0, 8'h00, "R1 status1 reset", 1);
    rd_reg(1'b1, 8'h00, "R1 status2 reset", 1);

    pulse(8'hA5, 4'h0);
    chk({7'd0, irq}, 8'h00, "R3 masked events keep irq low");
    rd_reg(1'b0, 8'hA5, "R2 events set status1", 4);
    rd_reg(1'b0, 8'h00, "R4 cleared after long read", 1);

    wr_mask(1'b0, 8'h04);
    pulse(8'h01, 4'h0);
    chk({7'd0, irq}, 8'h00, "R3 disabled bit no irq");
    pulse(8'h04, 4'h0);
    chk({7'd0, irq}, 8'h01, "R3 enabled bit raises irq");
    rd_reg(1'b1, 8'h80, "R7 INT bit mirrors irq", 1);
    rd_reg(1'b0, 8'h05, "R2 status1 two events", 2);
    chk({7'd0, irq}, 8'h00, "R4 irq drops after clear");

    // events during a long read of status1
    rd_begin(1'b0, 8'h00, "R4 empty read");
    @(negedge clk);
    pulse(8'h10, 4'h2);
    @(negedge clk);
    rd_end();
    rd_reg(1'b0, 8'h10, "R5 parked event after clear", 1);
    rd_reg(1'b1, 8'h02, "R5 other register set directly", 1);

    // event exactly on the clear edge
    rd_begin(1'b0, 8'h00, "R4 empty read 2");
    @(negedge clk); rd = 1'b0; evt_a = 8'h20;
    @(negedge clk); evt_a = '0;
    rd_reg(1'b0, 8'h20, "R5 event on clear edge", 1);

    lvl = 3'b101;
    wr_mask(1'b1, 8'h0F);
    rd_reg(1'b1, 8'h50, "R7 level bits shown", 1);
    rd_reg(1'b1, 8'h50, "R7 level bits not cleared", 1);
    chk({7'd0, irq}, 8'h00, "R7 levels raise no irq");
    lvl = 3'b000;

    solo = 1'b1;
    pulse(8'h00, 4'h1);
    rd_reg(1'b1, 8'h00, "R8 address change dropped", 1);
    solo = 1'b0;
    pulse(8'h00, 4'h1);
    rd_reg(1'b1, 8'h81, "R8 address change recorded", 1);

    wr_mask(1'b1, 8'hC0);
    chk({6'd0, dma}, 8'h03, "R9 dma enables");
    pulse(8'h00, 4'hF);
    chk({7'd0, irq}, 8'h00, "R9 dma bits are not masks");
    wr_mask(1'b1, 8'h0F);
    chk({6'd0, dma}, 8'h00, "R9 dma cleared");
    chk({7'd0, irq}, 8'h01, "R3 mask2 enables irq");

    pulse(8'hFF, 4'h0);
    @(negedge clk); pon = 1'b1;
    @(negedge clk); pon = 1'b0;
    chk({7'd0, irq}, 8'h00, "R6 irq low after pon");
    rd_reg(1'b0, 8'h00, "R6 status1 cleared by pon", 1);
    rd_reg(1'b1, 8'h00, "R6 status2 cleared by pon", 1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "scoreboard leftover");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule